// File: doc/BRIEF.md
# Bus controller status flag sequencer

This block keeps four status flags for a two-wire serial bus controller: start generated, 10-bit header sent, address sent or matched, and byte transfer finished. A separate bus engine reports what happens on the wire as one-cycle event strobes. The register file reports each software access to the first status register, the second status register and the data register as a one-cycle strobe. The block raises each flag when its qualifying event arrives. It lowers the flag only after software has made the matching two-step access: a read of the first status register, then the right second access.

A single pending bit records that the first status register has been read. The next access to any other register uses that bit up, whether or not the access clears a flag. Another read of the first status register arms it again. Lowering the enable input clears every flag and the pending bit, and holds them clear. Several set conditions are qualified: a NACK in the same cycle blocks the header, address and byte-finished flags; the byte-finished flag needs clock stretching; and in transmit it is held off when the next byte is the error-check byte.

Top module: `i2c_flag_seq`

## Requirements
- R1: While `rst_n` is low, all four flags and the pending bit are 0. Flags are output in the bit order {btf, addr, hdr, sb}.
- R2: While `en` is 0, all flags read 0 on the following edge, no event sets a flag, and the pending bit is dropped, so a second access after re-enable clears nothing.
- R3: `ev_start_gen` sets `flag_sb` on the next edge. The flag clears after an `acc_sr1_rd` cycle that is followed by an `acc_dr_wr` cycle.
- R4: `ev_hdr_ack` sets `flag_hdr` only while `cfg_addr10` is 1. The flag clears after a status-1 read that is followed by a data write.
- R5: `ev_addr_ack` (the last address byte acknowledged, as master) or `ev_addr_match` (as slave) sets `flag_addr`. The flag clears after a status-1 read that is followed by `acc_sr2_rd`; a data access does not clear it.
- R6: `ev_nack` in the same cycle stops `flag_hdr`, `flag_addr` and `flag_btf` from being set. `flag_sb` is not affected.
- R7: With `cfg_nostretch` at 0 and `cfg_tx` at 0, `ev_byte_rx` sets `flag_btf` only if `rx_full` is 1. With `cfg_nostretch` at 1, `flag_btf` never sets.
- R8: With `cfg_tx` at 1 and stretching enabled, `ev_tx_empty` sets `flag_btf`, except when `cfg_pec_en` and `pec_next` are both 1.
- R9: `flag_btf` clears after a status-1 read followed by a data read or a data write. When `cfg_tx` is 1, `ev_start_stop` also clears it on the next edge.
- R10: A status-1 read arms the pending bit. The first later access to the second status register or the data register consumes it. A second access without a status-1 read before it, or with another access in between, clears nothing.
- R11: If a flag's set event and its clearing access fall in the same cycle, the flag is 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Peripheral enable |
| cfg_nostretch | input | 1 | Clock stretching disabled |
| cfg_pec_en | input | 1 | Error-check byte enabled |
| cfg_tx | input | 1 | Transmit direction |
| cfg_addr10 | input | 1 | 10-bit addressing |
| rx_full | input | 1 | Receive data register holds an unread byte |
| pec_next | input | 1 | Next byte to send is the error-check byte |
| ev_start_gen | input | 1 | Start condition generated |
| ev_hdr_ack | input | 1 | 10-bit header byte acknowledged |
| ev_addr_ack | input | 1 | Last address byte acknowledged (master) |
| ev_nack | input | 1 | NACK received |
| ev_byte_rx | input | 1 | Byte received including its ACK |
| ev_tx_empty | input | 1 | Byte due for sending |
| ev_start_stop | input | 1 | Start or stop condition issued |
| ev_addr_match | input | 1 | Received address recognised (slave) |
| acc_sr1_rd | input | 1 | First status register read |
| acc_sr2_rd | input | 1 | Second status register read |
| acc_dr_rd | input | 1 | Data register read |
| acc_dr_wr | input | 1 | Data register write |
| flag_sb | output | 1 | Start generated flag |
| flag_hdr | output | 1 | Header sent flag |
| flag_addr | output | 1 | Address sent or matched flag |
| flag_btf | output | 1 | Byte transfer finished flag |

## Verification
The bench uses the package default of four flags, which is the only flag count the block has. At this size the bench can vary every configuration input and every strobe at once. Directed sequences cover each set rule, each clear rule and the cases where the pending bit is lost. A long pseudo-random sweep then changes the configuration every hundred cycles and compares all four flags on every edge against an arithmetic model. This sweep covers same-cycle collisions between set events, clearing accesses, NACKs and disable.

// File: rtl/i2c_flag_seq_pkg.sv
package i2c_flag_seq_pkg;
    localparam int unsigned NFLAG    = 4;
    localparam int unsigned IDX_SB   = 0;
    localparam int unsigned IDX_HDR  = 1;
    localparam int unsigned IDX_ADDR = 2;
    localparam int unsigned IDX_BTF  = 3;

    typedef logic [NFLAG-1:0] flag_vec_t;

    typedef struct packed {
        logic pend;
    } arm_state_t;

    typedef struct packed {
        logic q;
    } bit_state_t;
endpackage

// File: rtl/i2c_flag_seq_arm.sv
module i2c_flag_seq_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sr1_rd,
    input  logic sr2_rd,
    input  logic dr_rd,
    input  logic dr_wr,
    output logic pend_q
);
    import i2c_flag_seq_pkg::*;

    arm_state_t st_d, st_q;
    logic       second_acc;

    always_comb begin
        st_d       = st_q;
        second_acc = sr2_rd | dr_rd | dr_wr;
        if (!en) begin
            st_d.pend = 1'b0;
        end else if (sr1_rd) begin
            st_d.pend = 1'b1;
        end else if (second_acc) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;
endmodule

// File: rtl/i2c_flag_seq_setq.sv
module i2c_flag_seq_setq
    import i2c_flag_seq_pkg::*;
(
    input  logic      en,
    input  logic      cfg_nostretch,
    input  logic      cfg_pec_en,
    input  logic      cfg_tx,
    input  logic      cfg_addr10,
    input  logic      rx_full,
    input  logic      pec_next,
    input  logic      ev_start_gen,
    input  logic      ev_hdr_ack,
    input  logic      ev_addr_ack,
    input  logic      ev_nack,
    input  logic      ev_byte_rx,
    input  logic      ev_tx_empty,
    input  logic      ev_addr_match,
    output flag_vec_t set_vec
);
    logic acked;
    logic rx_done;
    logic tx_due;

    always_comb begin
        acked   = en & ~ev_nack;
        rx_done = ~cfg_tx & ev_byte_rx & rx_full;
        tx_due  = cfg_tx & ev_tx_empty & ~(cfg_pec_en & pec_next);
        set_vec           = '0;
        set_vec[IDX_SB]   = en & ev_start_gen;
        set_vec[IDX_HDR]  = acked & ev_hdr_ack & cfg_addr10;
        set_vec[IDX_ADDR] = acked & (ev_addr_ack | ev_addr_match);
        set_vec[IDX_BTF]  = acked & ~cfg_nostretch & (rx_done | tx_due);
    end
endmodule

// File: rtl/i2c_flag_seq_clrq.sv
module i2c_flag_seq_clrq
    import i2c_flag_seq_pkg::*;
(
    input  logic      en,
    input  logic      pend_q,
    input  logic      cfg_tx,
    input  logic      ev_start_stop,
    input  logic      sr2_rd,
    input  logic      dr_rd,
    input  logic      dr_wr,
    output flag_vec_t clr_vec
);
    logic armed;

    always_comb begin
        armed             = en & pend_q;
        clr_vec           = '0;
        clr_vec[IDX_SB]   = armed & dr_wr;
        clr_vec[IDX_HDR]  = armed & dr_wr;
        clr_vec[IDX_ADDR] = armed & sr2_rd;
        clr_vec[IDX_BTF]  = (armed & (dr_rd | dr_wr)) | (cfg_tx & ev_start_stop);
    end
endmodule

// File: rtl/i2c_flag_seq_bit.sv
module i2c_flag_seq_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set,
    input  logic clr,
    output logic q
);
    import i2c_flag_seq_pkg::*;

    bit_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en)      st_d.q = 1'b0;
        else if (set) st_d.q = 1'b1;
        else if (clr) st_d.q = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.q;
endmodule

// File: rtl/i2c_flag_seq.sv
module i2c_flag_seq
    import i2c_flag_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cfg_nostretch,
    input  logic cfg_pec_en,
    input  logic cfg_tx,
    input  logic cfg_addr10,
    input  logic rx_full,
    input  logic pec_next,
    input  logic ev_start_gen,
    input  logic ev_hdr_ack,
    input  logic ev_addr_ack,
    input  logic ev_nack,
    input  logic ev_byte_rx,
    input  logic ev_tx_empty,
    input  logic ev_start_stop,
    input  logic ev_addr_match,
    input  logic acc_sr1_rd,
    input  logic acc_sr2_rd,
    input  logic acc_dr_rd,
    input  logic acc_dr_wr,
    output logic flag_sb,
    output logic flag_hdr,
    output logic flag_addr,
    output logic flag_btf
);
    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    flag_vec_t flag_q;
    logic      pend_q;

    i2c_flag_seq_arm u_arm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .sr1_rd (acc_sr1_rd),
        .sr2_rd (acc_sr2_rd),
        .dr_rd  (acc_dr_rd),
        .dr_wr  (acc_dr_wr),
        .pend_q (pend_q)
    );

    i2c_flag_seq_setq u_setq (
        .en            (en),
        .cfg_nostretch (cfg_nostretch),
        .cfg_pec_en    (cfg_pec_en),
        .cfg_tx        (cfg_tx),
        .cfg_addr10    (cfg_addr10),
        .rx_full       (rx_full),
        .pec_next      (pec_next),
        .ev_start_gen  (ev_start_gen),
        .ev_hdr_ack    (ev_hdr_ack),
        .ev_addr_ack   (ev_addr_ack),
        .ev_nack       (ev_nack),
        .ev_byte_rx    (ev_byte_rx),
        .ev_tx_empty   (ev_tx_empty),
        .ev_addr_match (ev_addr_match),
        .set_vec       (set_vec)
    );

    i2c_flag_seq_clrq u_clrq (
        .en            (en),
        .pend_q        (pend_q),
        .cfg_tx        (cfg_tx),
        .ev_start_stop (ev_start_stop),
        .sr2_rd        (acc_sr2_rd),
        .dr_rd         (acc_dr_rd),
        .dr_wr         (acc_dr_wr),
        .clr_vec       (clr_vec)
    );

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        i2c_flag_seq_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .set   (set_vec[g]),
            .clr   (clr_vec[g]),
            .q     (flag_q[g])
        );
    end

    assign flag_sb   = flag_q[IDX_SB];
    assign flag_hdr  = flag_q[IDX_HDR];
    assign flag_addr = flag_q[IDX_ADDR];
    assign flag_btf  = flag_q[IDX_BTF];
endmodule

// File: rtl/i2c_flag_seq_chk.sv
module i2c_flag_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cfg_nostretch,
    input logic cfg_pec_en,
    input logic cfg_tx,
    input logic cfg_addr10,
    input logic pec_next,
    input logic ev_start_gen,
    input logic ev_addr_ack,
    input logic ev_addr_match,
    input logic ev_nack,
    input logic acc_sr1_rd,
    input logic acc_sr2_rd,
    input logic flag_sb,
    input logic flag_hdr,
    input logic flag_addr,
    input logic flag_btf,
    input logic pend_q
);
    p_disable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !flag_sb && !flag_hdr && !flag_addr && !flag_btf);

    p_start_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en && ev_start_gen |=> flag_sb);

    p_hdr_needs_10bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en && !cfg_addr10 && !flag_hdr |=> !flag_hdr);

    p_addr_seq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en && pend_q && acc_sr2_rd && !ev_addr_ack && !ev_addr_match |=> !flag_addr);

    p_nack_hdr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack && !flag_hdr |=> !flag_hdr);

    p_nack_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack && !flag_addr |=> !flag_addr);

    p_nack_btf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack && !flag_btf |=> !flag_btf);

    p_nostretch_btf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_nostretch && !flag_btf |=> !flag_btf);

    p_pec_holds_btf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tx && cfg_pec_en && pec_next && !flag_btf |=> !flag_btf);

    p_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en && acc_sr1_rd |=> pend_q);

    p_no_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q && !acc_sr1_rd |=> !pend_q);
endmodule

bind i2c_flag_seq i2c_flag_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .cfg_nostretch (cfg_nostretch),
    .cfg_pec_en    (cfg_pec_en),
    .cfg_tx        (cfg_tx),
    .cfg_addr10    (cfg_addr10),
    .pec_next      (pec_next),
    .ev_start_gen  (ev_start_gen),
    .ev_addr_ack   (ev_addr_ack),
    .ev_addr_match (ev_addr_match),
    .ev_nack       (ev_nack),
    .acc_sr1_rd    (acc_sr1_rd),
    .acc_sr2_rd    (acc_sr2_rd),
    .flag_sb       (flag_sb),
    .flag_hdr      (flag_hdr),
    .flag_addr     (flag_addr),
    .flag_btf      (flag_btf),
    .pend_q        (pend_q)
);

// File: tb/tb_i2c_flag_seq.sv
`timescale 1ns/1ps
module tb_i2c_flag_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic cfg_nostretch = 0, cfg_pec_en = 0, cfg_tx = 0, cfg_addr10 = 0;
    logic rx_full = 0, pec_next = 0;
    logic ev_start_gen = 0, ev_hdr_ack = 0, ev_addr_ack = 0, ev_nack = 0;
    logic ev_byte_rx = 0, ev_tx_empty = 0, ev_start_stop = 0, ev_addr_match = 0;
    logic acc_sr1_rd = 0, acc_sr2_rd = 0, acc_dr_rd = 0, acc_dr_wr = 0;
    logic flag_sb, flag_hdr, flag_addr, flag_btf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [3:0] m_flags = 4'b0;   // {btf, addr, hdr, sb}
    logic       m_pend  = 1'b0;

    always #5 clk = ~clk;

    i2c_flag_seq dut (.*);

    function automatic logic [3:0] dut_flags();
        return {flag_btf, flag_addr, flag_hdr, flag_sb};
    endfunction

    task automatic chk(input string tag, input logic [3:0] exp);
        n_chk++;
        if (dut_flags() !== exp) begin
            n_bad++;
            $display("FAIL %s: flags {btf,addr,hdr,sb} actual %b expected %b", tag, dut_flags(), exp);
        end
    endtask

    task automatic clr_strobes();
        ev_start_gen = 0; ev_hdr_ack = 0; ev_addr_ack = 0; ev_nack = 0;
        ev_byte_rx = 0; ev_tx_empty = 0; ev_start_stop = 0; ev_addr_match = 0;
        acc_sr1_rd = 0; acc_sr2_rd = 0; acc_dr_rd = 0; acc_dr_wr = 0;
    endtask

    // next-state model built from R2..R11
    task automatic cyc();
        logic [3:0] s, c, n;
        logic arm, pn;
        arm  = en & m_pend;
        s[0] = ev_start_gen;                                          // R3
        s[1] = ev_hdr_ack & cfg_addr10 & ~ev_nack;                    // R4 R6
        s[2] = (ev_addr_ack | ev_addr_match) & ~ev_nack;              // R5 R6
        s[3] = ~cfg_nostretch & ~ev_nack &
               ((~cfg_tx & ev_byte_rx & rx_full) |
                (cfg_tx & ev_tx_empty & ~(cfg_pec_en & pec_next)));   // R7 R8
        c[0] = arm & acc_dr_wr;
        c[1] = arm & acc_dr_wr;
        c[2] = arm & acc_sr2_rd;
        c[3] = (arm & (acc_dr_rd | acc_dr_wr)) | (cfg_tx & ev_start_stop); // R9
        n    = en ? (s | (m_flags & ~c)) : 4'b0;                      // R2 R11
        pn   = en & (acc_sr1_rd | (m_pend & ~(acc_sr2_rd | acc_dr_rd | acc_dr_wr))); // R10
        @(posedge clk);
        #1;
        m_flags = n;
        m_pend  = pn;
        clr_strobes();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset clears flags", 4'b0000);
        rst_n = 1; en = 1;
        cyc();
        chk("R1 idle after reset", 4'b0000);

        // R3 start flag set and two-step clear
        ev_start_gen = 1; cyc();
        chk("R3 start sets sb", 4'b0001);
        acc_sr1_rd = 1; cyc();
        chk("R3 sr1 read alone keeps sb", 4'b0001);
        acc_dr_wr = 1; cyc();
        chk("R3 sr1 then dr write clears sb", 4'b0000);

        // R10 sequence rules
        ev_start_gen = 1; cyc();
        acc_dr_wr = 1; cyc();
        chk("R10 dr write without sr1 read ignored", 4'b0001);
        acc_sr1_rd = 1; cyc();
        acc_dr_rd = 1; cyc();
        acc_dr_wr = 1; cyc();
        chk("R10 intervening access abandons sequence", 4'b0001);
        acc_sr1_rd = 1; cyc();
        acc_sr1_rd = 1; cyc();
        acc_dr_wr = 1; cyc();
        chk("R10 repeated sr1 read re-arms", 4'b0000);

        // R4 header flag
        cfg_addr10 = 0; ev_hdr_ack = 1; cyc();
        chk("R4 header ack ignored in 7-bit", 4'b0000);
        cfg_addr10 = 1; ev_hdr_ack = 1; cyc();
        chk("R4 header ack sets hdr in 10-bit", 4'b0010);
        acc_sr1_rd = 1; cyc();
        acc_dr_wr = 1; cyc();
        chk("R4 sr1 then dr write clears hdr", 4'b0000);
        cfg_addr10 = 0;

        // R5 address flag
        ev_addr_ack = 1; cyc();
        chk("R5 master address ack sets addr", 4'b0100);
        acc_sr1_rd = 1; cyc();
        acc_dr_wr = 1; cyc();
        chk("R5 dr write does not clear addr", 4'b0100);
        acc_sr1_rd = 1; cyc();
        acc_sr2_rd = 1; cyc();
        chk("R5 sr1 then sr2 clears addr", 4'b0000);
        ev_addr_match = 1; cyc();
        chk("R5 slave match sets addr", 4'b0100);
        acc_sr1_rd = 1; cyc();
        acc_sr2_rd = 1; cyc();
        chk("R5 slave addr cleared", 4'b0000);

        // R6 nack suppresses
        cfg_addr10 = 1; rx_full = 1;
        ev_nack = 1; ev_hdr_ack = 1; ev_addr_ack = 1; ev_byte_rx = 1; ev_start_gen = 1; cyc();
        chk("R6 nack blocks hdr addr btf, not sb", 4'b0001);
        acc_sr1_rd = 1; cyc();
        acc_dr_wr = 1; cyc();
        cfg_addr10 = 0;

        // R7 receive byte finished
        rx_full = 0; ev_byte_rx = 1; cyc();
        chk("R7 byte rx with empty rx register ignored", 4'b0000);
        rx_full = 1; ev_byte_rx = 1; cyc();
        chk("R7 byte rx with rx_full sets btf", 4'b1000);
        acc_sr1_rd = 1; cyc();
        acc_dr_rd = 1; cyc();
        chk("R9 sr1 then dr read clears btf", 4'b0000);
        cfg_nostretch = 1; ev_byte_rx = 1; cyc();
        chk("R7 no stretch blocks btf", 4'b0000);
        cfg_nostretch = 0; rx_full = 0;

        // R8 / R9 transmit
        cfg_tx = 1; ev_tx_empty = 1; cyc();
        chk("R8 tx empty sets btf", 4'b1000);
        ev_start_stop = 1; cyc();
        chk("R9 start/stop clears btf in transmit", 4'b0000);
        cfg_pec_en = 1; pec_next = 1; ev_tx_empty = 1; cyc();
        chk("R8 pec byte next blocks btf", 4'b0000);
        pec_next = 0; ev_tx_empty = 1; cyc();
        chk("R8 pec enabled, data byte next sets btf", 4'b1000);
        acc_sr1_rd = 1; cyc();
        acc_dr_wr = 1; cyc();
        chk("R9 sr1 then dr write clears btf", 4'b0000);
        cfg_tx = 0; cfg_pec_en = 0;
        ev_byte_rx = 1; rx_full = 1; cyc();
        ev_start_stop = 1; cyc();
        chk("R9 start/stop keeps btf in receive", 4'b1000);
        acc_sr1_rd = 1; cyc();
        acc_dr_rd = 1; cyc();
        rx_full = 0;

        // R11 set wins
        ev_start_gen = 1; cyc();
        acc_sr1_rd = 1; cyc();
        acc_dr_wr = 1; ev_start_gen = 1; cyc();
        chk("R11 set beats clear in same cycle", 4'b0001);
        acc_sr1_rd = 1; cyc();
        acc_dr_wr = 1; cyc();

        // R2 disable
        ev_start_gen = 1; ev_addr_ack = 1; cyc();
        chk("R2 flags set before disable", 4'b0101);
        en = 0; cyc();
        chk("R2 disable clears flags", 4'b0000);
        ev_start_gen = 1; ev_addr_match = 1; cyc();
        chk("R2 events ignored while disabled", 4'b0000);
        en = 1; ev_start_gen = 1; cyc();
        acc_sr1_rd = 1; cyc();
        en = 0; cyc();
        en = 1; ev_start_gen = 1; cyc();
        acc_dr_wr = 1; cyc();
        chk("R2 disable drops pending sequence", 4'b0001);
        acc_sr1_rd = 1; cyc();
        acc_dr_wr = 1; cyc();
        chk("R3 final clear", 4'b0000);

        // pseudo-random sweep against the model (R2..R11)
        for (int blk = 0; blk < 40; blk++) begin
            {cfg_nostretch, cfg_pec_en, cfg_tx, cfg_addr10} = 4'(blk);
            for (int k = 0; k < 100; k++) begin
                en            = ($urandom_range(0, 63) != 0);
                rx_full       = $urandom_range(0, 1) != 0;
                pec_next      = $urandom_range(0, 1) != 0;
                ev_start_gen  = $urandom_range(0, 7) == 0;
                ev_hdr_ack    = $urandom_range(0, 7) == 0;
                ev_addr_ack   = $urandom_range(0, 7) == 0;
                ev_nack       = $urandom_range(0, 7) == 0;
                ev_byte_rx    = $urandom_range(0, 5) == 0;
                ev_tx_empty   = $urandom_range(0, 5) == 0;
                ev_start_stop = $urandom_range(0, 9) == 0;
                ev_addr_match = $urandom_range(0, 9) == 0;
                acc_sr1_rd    = $urandom_range(0, 2) == 0;
                acc_sr2_rd    = $urandom_range(0, 4) == 0;
                acc_dr_rd     = $urandom_range(0, 4) == 0;
                acc_dr_wr     = $urandom_range(0, 4) == 0;
                cyc();
                chk("R11 sweep model R2..R10", m_flags);
            end
        end
        finish_run();
    end
endmodule